// File: doc/BRIEF.md
# Host Byte-wide Data Register Port

This block is the host-facing side of a DSP coprocessor's mailbox. A host with an 8-bit bus reaches a 16-bit data register and a 16-bit status register through a single byte lane. One select line picks the status byte or the data register. The DSP side, in the same block, can load the data register, read it, and load the status register.

Sixteen-bit transfers are split into two host accesses, low byte first. A sequencing bit in the status register remembers which half comes next. A request flag in the status register tells the host that the DSP has put new data in the register or is waiting for it. The flag is raised by the DSP and dropped by the host only when the last byte of a transfer completes. A width bit in the status register switches the port to single-byte transfers.

Top module: `host_byte_port`

## Requirements
- R1: After reset the data register reads 0x0000 and the status register reads 0x0000. This means the request flag (status bit 15) is 0, the sequencing flag (status bit 12) is 0 and the width bit (status bit 10) is 0, which selects 16-bit mode.
- R2: A host read with `hostSel` at 0 returns status bits 15..8 in the same cycle. A host write with `hostSel` at 0 changes neither register.
- R3: In 16-bit mode, a host data read with the sequencing flag at 0 returns data bits 7..0 and sets the sequencing flag. A host data read with the flag at 1 returns data bits 15..8 and clears both the sequencing flag and the request flag.
- R4: In 16-bit mode, a host data write with the sequencing flag at 0 replaces data bits 7..0 and sets the flag. A write with the flag at 1 replaces data bits 15..8 and clears both the sequencing flag and the request flag.
- R5: In 8-bit mode (width bit at 1), every host data read returns data bits 7..0. Every host data write replaces data bits 7..0 and leaves bits 15..8 unchanged. Each such access clears the request flag and leaves the sequencing flag unchanged.
- R6: A DSP data load puts `dspDrWrData` into the data register and sets the request flag on the next cycle.
- R7: A DSP data read with `dspDrAck` at 1 sets the request flag. Reading `dspDrRdData` without the strobe changes no state.
- R8: A DSP status load keeps the old values of status bits 15, 12 and 6..2 (mask 0x907C) and takes all other bits from `dspSrWrData`.
- R9: When a DSP data load or acknowledged DSP data read falls in the same cycle as a host data access, the DSP side wins. The host access then changes neither the data register nor the sequencing flag, and it does not clear the request flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRdStb | input | 1 | Single-cycle host read strobe |
| hostWrStb | input | 1 | Single-cycle host write strobe |
| hostSel | input | 1 | 0 selects the status byte, 1 selects the data register |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, valid in the strobe cycle |
| dspDrLoad | input | 1 | DSP loads the data register |
| dspDrWrData | input | 16 | Value for a DSP data load |
| dspDrAck | input | 1 | DSP data read that raises the request flag |
| dspDrRdData | output | 16 | Current data register |
| dspSrLoad | input | 1 | DSP loads the status register through the keep mask |
| dspSrWrData | input | 16 | Value for a DSP status load |
| srOut | output | 16 | Current status register |

## Verification
The byte sequencer is exercised three ways:
- Paired host reads and paired host writes in 16-bit mode show whether the low half really comes first and whether the request flag survives the first byte.
- Repeated single accesses in 8-bit mode show that the sequencing flag is left alone and that the upper byte is preserved.
- Host accesses placed in the same cycle as DSP loads and acknowledged reads separate correct DSP priority from a merged update.

Status loads are applied both with the request and sequencing flags set and with them clear, which shows whether the keep mask protects those bits. Status loads are also applied while a 16-bit transfer is half done.

// File: rtl/host_byte_port_pkg.sv
package host_byte_port_pkg;

  // Strobes from the control module to the register datapath.
  typedef struct packed {
    logic drLoad;    // DSP value into the whole data register
    logic wrLo;      // host byte into the low lane
    logic wrHi;      // host byte into the high lane
    logic srLoad;    // masked DSP status load
    logic setRqm;    // raise the request flag
    logic clrRqm;    // drop the request flag
    logic setDrs;    // next host byte is the high half
    logic clrDrs;    // next host byte is the low half
    logic rdStatus;  // host read mux picks the status byte
    logic rdHi;      // host read mux picks the high data lane
  } portStrobes_t;

endpackage

// File: rtl/host_byte_port_ctrl.sv
module host_byte_port_ctrl
  import host_byte_port_pkg::*;
(
  input  logic         hostRdStb,
  input  logic         hostWrStb,
  input  logic         hostSel,
  input  logic         dspDrLoad,
  input  logic         dspDrAck,
  input  logic         dspSrLoad,
  input  logic         drsNow,
  input  logic         drcNow,
  output portStrobes_t st
);

  logic dspOwns;
  logic hostData;
  logic narrow;
  logic secondHalf;

  always_comb begin
    dspOwns    = dspDrLoad | dspDrAck;
    hostData   = (hostRdStb | hostWrStb) & hostSel & ~dspOwns;
    narrow     = drcNow;
    secondHalf = ~narrow & drsNow;

    st          = '0;
    st.drLoad   = dspDrLoad;
    st.srLoad   = dspSrLoad;
    st.setRqm   = dspOwns;
    st.wrLo     = hostData & hostWrStb & ~secondHalf;
    st.wrHi     = hostData & hostWrStb & secondHalf;
    st.setDrs   = hostData & ~narrow & ~drsNow;
    st.clrDrs   = hostData & secondHalf;
    st.clrRqm   = hostData & (narrow | secondHalf);
    st.rdStatus = ~hostSel;
    st.rdHi     = secondHalf;
  end

endmodule

// File: rtl/host_byte_port_dp.sv
module host_byte_port_dp
  import host_byte_port_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] KEEP_MASK = 16'h907C
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  portStrobes_t          st,
  input  logic [BYTE_W-1:0]     hostWrData,
  input  logic [2*BYTE_W-1:0]   dspDrWrData,
  input  logic [2*BYTE_W-1:0]   dspSrWrData,
  output logic [BYTE_W-1:0]     hostRdData,
  output logic [2*BYTE_W-1:0]   drQ,
  output logic [2*BYTE_W-1:0]   srQ,
  output logic                  drsNow,
  output logic                  drcNow
);

  localparam int SR_W    = 2 * BYTE_W;
  localparam int LANES   = 2;
  localparam int RQM_BIT = SR_W - 1;
  localparam int DRS_BIT = SR_W - 4;
  localparam int DRC_BIT = SR_W - 6;

  logic [LANES-1:0] laneWe;
  assign laneWe = {st.wrHi, st.wrLo};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        drQ[lane*BYTE_W +: BYTE_W] <= '0;
      else if (st.drLoad)
        drQ[lane*BYTE_W +: BYTE_W] <= dspDrWrData[lane*BYTE_W +: BYTE_W];
      else if (laneWe[lane])
        drQ[lane*BYTE_W +: BYTE_W] <= hostWrData;
    end
  end

  logic [SR_W-1:0] srNext;

  always_comb begin
    srNext = srQ;
    if (st.srLoad) srNext = (srQ & KEEP_MASK) | (dspSrWrData & ~KEEP_MASK);
    if (st.setRqm) srNext[RQM_BIT] = 1'b1;
    if (st.clrRqm) srNext[RQM_BIT] = 1'b0;
    if (st.setDrs) srNext[DRS_BIT] = 1'b1;
    if (st.clrDrs) srNext[DRS_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srQ <= '0;
    else       srQ <= srNext;
  end

  assign drsNow = srQ[DRS_BIT];
  assign drcNow = srQ[DRC_BIT];

  always_comb begin
    if (st.rdStatus)  hostRdData = srQ[SR_W-1:BYTE_W];
    else if (st.rdHi) hostRdData = drQ[SR_W-1:BYTE_W];
    else              hostRdData = drQ[BYTE_W-1:0];
  end

endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
  import host_byte_port_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] KEEP_MASK = 16'h907C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostRdStb,
  input  logic                hostWrStb,
  input  logic                hostSel,
  input  logic [BYTE_W-1:0]   hostWrData,
  output logic [BYTE_W-1:0]   hostRdData,
  input  logic                dspDrLoad,
  input  logic [2*BYTE_W-1:0] dspDrWrData,
  input  logic                dspDrAck,
  output logic [2*BYTE_W-1:0] dspDrRdData,
  input  logic                dspSrLoad,
  input  logic [2*BYTE_W-1:0] dspSrWrData,
  output logic [2*BYTE_W-1:0] srOut
);

  portStrobes_t st;
  logic drsNow;
  logic drcNow;

  host_byte_port_ctrl u_ctrl (
    .hostRdStb (hostRdStb),
    .hostWrStb (hostWrStb),
    .hostSel   (hostSel),
    .dspDrLoad (dspDrLoad),
    .dspDrAck  (dspDrAck),
    .dspSrLoad (dspSrLoad),
    .drsNow    (drsNow),
    .drcNow    (drcNow),
    .st        (st)
  );

  host_byte_port_dp #(
    .BYTE_W    (BYTE_W),
    .KEEP_MASK (KEEP_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .hostWrData  (hostWrData),
    .dspDrWrData (dspDrWrData),
    .dspSrWrData (dspSrWrData),
    .hostRdData  (hostRdData),
    .drQ         (dspDrRdData),
    .srQ         (srOut),
    .drsNow      (drsNow),
    .drcNow      (drcNow)
  );

endmodule

// File: rtl/host_byte_port_chk.sv
module host_byte_port_chk #(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] KEEP_MASK = 16'h907C
) (
  input logic                clk,
  input logic                rstN,
  input logic                hostRdStb,
  input logic                hostWrStb,
  input logic                hostSel,
  input logic [BYTE_W-1:0]   hostRdData,
  input logic                dspDrLoad,
  input logic [2*BYTE_W-1:0] dspDrWrData,
  input logic                dspDrAck,
  input logic [2*BYTE_W-1:0] dspDrRdData,
  input logic                dspSrLoad,
  input logic [2*BYTE_W-1:0] dspSrWrData,
  input logic [2*BYTE_W-1:0] srOut
);

  localparam int SR_W = 2 * BYTE_W;
  localparam int RQM  = SR_W - 1;
  localparam int DRS  = SR_W - 4;
  localparam int DRC  = SR_W - 6;

  logic dspOwns;
  logic hostData;
  logic anyStb;
  assign dspOwns  = dspDrLoad | dspDrAck;
  assign hostData = (hostRdStb | hostWrStb) & hostSel;
  assign anyStb   = hostRdStb | hostWrStb | dspOwns | dspSrLoad;

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    hostRdStb && !hostSel |-> hostRdData == srOut[SR_W-1:BYTE_W]); // R2

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    hostWrStb && !hostSel && !hostRdStb && !dspOwns && !dspSrLoad
    |=> $stable(srOut) && $stable(dspDrRdData)); // R2

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    hostData && !dspOwns && !srOut[DRC] && !srOut[DRS] |=> srOut[DRS]); // R3

  AST_SECOND_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    hostData && !dspOwns && !srOut[DRC] && srOut[DRS]
    |=> !srOut[RQM] && !srOut[DRS]); // R3

  AST_NARROW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    hostWrStb && hostSel && srOut[DRC] && !dspOwns
    |=> dspDrRdData[SR_W-1:BYTE_W] == $past(dspDrRdData[SR_W-1:BYTE_W]) && !srOut[RQM]); // R5

  AST_LOAD_SETS_RQM: assert property (@(posedge clk) disable iff (!rstN)
    dspDrLoad |=> srOut[RQM] && dspDrRdData == $past(dspDrWrData)); // R6

  AST_ACK_SETS_RQM: assert property (@(posedge clk) disable iff (!rstN)
    dspDrAck |=> srOut[RQM]); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !anyStb |=> $stable(srOut) && $stable(dspDrRdData)); // R7

  AST_SR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    dspSrLoad && !hostData && !dspOwns
    |=> srOut == (($past(srOut) & KEEP_MASK) | ($past(dspSrWrData) & ~KEEP_MASK))); // R8

  AST_DSP_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    dspOwns && hostData |=> srOut[DRS] == $past(srOut[DRS]) && srOut[RQM]); // R9

endmodule

bind host_byte_port host_byte_port_chk #(
  .BYTE_W    (BYTE_W),
  .KEEP_MASK (KEEP_MASK)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostRdStb   (hostRdStb),
  .hostWrStb   (hostWrStb),
  .hostSel     (hostSel),
  .hostRdData  (hostRdData),
  .dspDrLoad   (dspDrLoad),
  .dspDrWrData (dspDrWrData),
  .dspDrAck    (dspDrAck),
  .dspDrRdData (dspDrRdData),
  .dspSrLoad   (dspSrLoad),
  .dspSrWrData (dspSrWrData),
  .srOut       (srOut)
);

// File: tb/tb_host_byte_port.sv
module tb_host_byte_port;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostRdStb, hostWrStb, hostSel;
  logic [7:0]  hostWrData, hostRdData;
  logic        dspDrLoad, dspDrAck, dspSrLoad;
  logic [15:0] dspDrWrData, dspSrWrData, dspDrRdData, srOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_byte_port dut (
    .clk(clk), .rstN(rstN),
    .hostRdStb(hostRdStb), .hostWrStb(hostWrStb), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .dspDrLoad(dspDrLoad), .dspDrWrData(dspDrWrData), .dspDrAck(dspDrAck),
    .dspDrRdData(dspDrRdData), .dspSrLoad(dspSrLoad), .dspSrWrData(dspSrWrData),
    .srOut(srOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";
  int mDr = 0;
  int mSr = 0;
  logic [7:0] lastRd;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One clock of stimulus; called at a falling edge.
  task automatic step(input bit rd, input bit wr, input bit sel, input logic [7:0] wd,
                      input bit ld, input logic [15:0] ldv, input bit ack,
                      input bit sl, input logic [15:0] slv);
    int expRd;
    int oldSr;
    bit drc, drs;
    hostRdStb = rd; hostWrStb = wr; hostSel = sel; hostWrData = wd;
    dspDrLoad = ld; dspDrWrData = ldv; dspDrAck = ack;
    dspSrLoad = sl; dspSrWrData = slv;
    oldSr = mSr;
    drc = ((oldSr >> 10) & 1) != 0;
    drs = ((oldSr >> 12) & 1) != 0;
    if (!sel)            expRd = (oldSr >> 8) & 'hFF;
    else if (!drc && drs) expRd = (mDr >> 8) & 'hFF;
    else                 expRd = mDr & 'hFF;
    #1;
    lastRd = hostRdData;
    if (rd) check(curReq, "host read byte", {8'h00, hostRdData}, expRd[15:0]);
    @(posedge clk);
    if (sl) mSr = (oldSr & 'h907C) | (int'(slv) & 'h6F83);
    if (ld || ack) mSr = mSr | 'h8000;
    if (ld) mDr = int'(ldv);
    if ((rd || wr) && sel && !(ld || ack)) begin
      if (drc) begin
        if (wr) mDr = (mDr & 'hFF00) | int'(wd);
        mSr = mSr & 'h7FFF;
      end else if (!drs) begin
        if (wr) mDr = (mDr & 'hFF00) | int'(wd);
        mSr = mSr | 'h1000;
      end else begin
        if (wr) mDr = (mDr & 'h00FF) | (int'(wd) << 8);
        mSr = mSr & 'h6FFF;
      end
    end
    @(negedge clk);
    hostRdStb = 0; hostWrStb = 0; dspDrLoad = 0; dspDrAck = 0; dspSrLoad = 0;
    check(curReq, "data register", dspDrRdData, mDr[15:0]);
    check(curReq, "status register", srOut, mSr[15:0]);
  endtask

  task automatic hostRead(input bit sel);       step(1,0,sel,8'h00,0,16'h0,0,0,16'h0); endtask
  task automatic hostWrite(input bit sel, input logic [7:0] d); step(0,1,sel,d,0,16'h0,0,0,16'h0); endtask
  task automatic dspLoad(input logic [15:0] v); step(0,0,1,8'h00,1,v,0,0,16'h0); endtask
  task automatic srLoad(input logic [15:0] v);  step(0,0,1,8'h00,0,16'h0,0,1,v); endtask
  task automatic idle();                        step(0,0,1,8'h00,0,16'h0,0,0,16'h0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 0;
    hostRdStb = 0; hostWrStb = 0; hostSel = 0; hostWrData = 0;
    dspDrLoad = 0; dspDrWrData = 0; dspDrAck = 0; dspSrLoad = 0; dspSrWrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    curReq = "R1";
    check("R1", "reset data", dspDrRdData, 16'h0000);
    check("R1", "reset status", srOut, 16'h0000);
    idle();

    // R8: status load through the keep mask
    curReq = "R8";
    srLoad(16'hFFFF);
    check("R8", "masked status", srOut, 16'h6F83);

    // R2: status byte reads, status writes ignored
    curReq = "R2";
    hostRead(0);
    check("R2", "status byte", {8'h00, lastRd}, 16'h006F);
    hostWrite(0, 8'hAA);
    check("R2", "status after ignored write", srOut, 16'h6F83);
    srLoad(16'h0000);

    // R6: DSP load raises the request flag
    curReq = "R6";
    dspLoad(16'hBEEF);
    check("R6", "request flag", {15'h0, srOut[15]}, 16'h0001);

    // R3: two-byte host read, low first
    curReq = "R3";
    hostRead(1);
    check("R3", "first byte", {8'h00, lastRd}, 16'h00EF);
    check("R3", "request kept after first", {15'h0, srOut[15]}, 16'h0001);
    hostRead(1);
    check("R3", "second byte", {8'h00, lastRd}, 16'h00BE);
    check("R3", "flags cleared", srOut, 16'h0000);

    // R4: two-byte host write
    curReq = "R4";
    hostWrite(1, 8'h34);
    hostWrite(1, 8'h12);
    check("R4", "assembled word", dspDrRdData, 16'h1234);

    // R7: acknowledged read vs plain read
    curReq = "R7";
    step(0,0,1,8'h00,0,16'h0,1,0,16'h0);
    check("R7", "ack sets request", {15'h0, srOut[15]}, 16'h0001);
    idle();
    check("R7", "plain read keeps word", dspDrRdData, 16'h1234);

    // R8 again: keep request and sequencing flags mid-transfer
    curReq = "R8";
    hostWrite(1, 8'h99);
    srLoad(16'h0000);
    check("R8", "kept flags", srOut, 16'h9000);
    hostWrite(1, 8'h88);

    // R5: 8-bit mode
    curReq = "R5";
    srLoad(16'h0400);
    dspLoad(16'h1256);
    hostWrite(1, 8'h77);
    check("R5", "high byte kept", dspDrRdData, 16'h1277);
    dspLoad(16'hA5C3);
    hostRead(1);
    check("R5", "narrow read byte", {8'h00, lastRd}, 16'h00C3);
    hostRead(1);
    check("R5", "narrow read repeat", {8'h00, lastRd}, 16'h00C3);
    check("R5", "status after narrow", srOut, 16'h0400);

    // R9: DSP priority over same-cycle host access
    curReq = "R9";
    srLoad(16'h0000);
    step(0,1,1,8'h11,1,16'h7777,0,0,16'h0);
    check("R9", "DSP load wins", dspDrRdData, 16'h7777);
    check("R9", "sequencing untouched", {15'h0, srOut[12]}, 16'h0000);
    hostRead(1);
    step(1,0,1,8'h00,0,16'h0,1,0,16'h0);
    check("R9", "sequencing held under ack", {15'h0, srOut[12]}, 16'h0001);
    hostRead(1);

    // R4/R3 sweep over several words
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      w = 16'h0F1E + 16'(i) * 16'h2357;
      curReq = "R4";
      hostWrite(1, w[7:0]);
      hostWrite(1, w[15:8]);
      check("R4", "sweep word", dspDrRdData, w);
      curReq = "R3";
      dspLoad(~w);
      hostRead(1);
      hostRead(1);
    end

    finish();
  end

endmodule